// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with Strap-Selected Address

This block is the bus-side half of a register-mapped peripheral on a two-wire I2C/SMBus link. A fast system clock oversamples the clock and data lines. Each line first passes through a synchroniser and then a short agreement filter. The filtered lines are checked for START, repeated START and STOP conditions. Bytes are shifted in and out, and the block answers each byte with ACK or NACK through an open-drain pull-down enable on the data line.

The block answers a 7-bit bus address made of a fixed `1010` prefix and a 2-bit board strap code. The last address bit is ignored. After a write address, the first byte is a command, which is handed to the register side by a one-cycle strobe. The bytes after it are handed over as write data. After a read address, the block asks the register side for bytes and sends them MSB first until the master declines one. The command is refused when the device is rebooting, when a nonvolatile write is in progress, or when the command value is above a configured limit.

Top module: `i2c_strap_slave`

## Requirements
- R1: During and directly after a synchronous reset, `sda_oe` is low and `cmd_valid`, `wr_valid` and `rd_req` are low.
- R2: An address byte whose upper six bits equal `1010` followed by `strap_code` (MSB first) is acknowledged by driving `sda_oe` high during the 9th clock. Bit 1 of the byte is ignored, and bit 0 selects read (1) or write (0).
- R3: An address byte that does not match is not acknowledged. Until the next START, the block does not drive the data line and raises no strobe.
- R4: SDA falling while SCL is high is a START. A repeated START in the middle of a transfer restarts address reception, in the same way as a first START.
- R5: SDA rising while SCL is high is a STOP, and it returns the block to idle from any point of a transfer. Bytes clocked after it without a new START are not acknowledged.
- R6: A STOP that occurs in the same SCL-high interval as the START before it is ignored, and the address phase continues.
- R7: The first byte after a matching write address is the command. When it is accepted, it is acknowledged and `cmd_valid` pulses for one cycle with the byte on `cmd_byte`.
- R8: The command is not acknowledged and `cmd_valid` stays low when `busy_reboot` or `busy_nvm` is high, or when the command value exceeds `CMD_LIMIT`. The following bytes of that transfer are then not acknowledged and produce no `wr_valid`.
- R9: Each byte after an accepted command is acknowledged, and `wr_valid` pulses for one cycle with the byte on `wr_data`.
- R10: After a matching read address, `rd_req` pulses once for each byte to be sent. `rd_data` is sampled on the SCL fall that follows, and the byte is sent MSB first, a 0 bit being sent by driving `sda_oe` high.
- R11: A master ACK on the 9th clock of a read byte requests and sends another byte. A master NACK releases the data line, and no further `rd_req` is raised until a new START.
- R12: Pulses on SCL or SDA that last fewer than three system clocks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_code | input | 2 | Encoded address strap |
| busy_reboot | input | 1 | Device reboot in progress |
| busy_nvm | input | 1 | Nonvolatile write in progress |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_byte | output | 8 | Accepted command value |
| wr_valid | output | 1 | One-cycle strobe for a write data byte |
| wr_data | output | 8 | Write data byte |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_data | input | 8 | Read byte supplied by the register side |

## Verification
The bench builds the block with `CMD_LIMIT` = 63, which puts the command bound at 0x3F, so both 0x3F (accepted) and 0x40 (refused) can be sent in ordinary transfers. It keeps a two-stage synchroniser and a three-sample filter. With these values, a two-clock pulse is just too short to pass the filter, and the bench injects such pulses on both lines. All four strap codes appear in the vector table, together with a byte that has the ignored address bit set.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [3:0] ADDR_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RDAT_ACK, ST_HOLD
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      win_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&win_q)       line_o <= 1'b1;
      else if (~|win_q) line_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cs_cond_detect.sv
module i2cs_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q, start_hi_q, stop_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      start_hi_q <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (start_det)     start_hi_q <= 1'b1;
      else if (scl_fall) start_hi_q <= 1'b0;
    end
  end

  always_comb begin
    scl_rise  = scl_f & ~scl_q;
    scl_fall  = ~scl_f & scl_q;
    start_det = scl_f & scl_q & sda_q & ~sda_f;
    stop_raw  = scl_f & scl_q & ~sda_q & sda_f;
    stop_det  = stop_raw & ~start_hi_q;
  end
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int CMD_LIMIT   = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap_code,
  input  logic              busy_reboot,
  input  logic              busy_nvm,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  input  logic [BYTE_W-1:0] rd_data
);
  localparam logic [BYTE_W-1:0] CMD_MAX  = BYTE_W'(CMD_LIMIT);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W);

  logic [1:0] raw_lines, filt_lines;
  logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2cs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) filt_i (
      .clk(clk), .rst(rst), .line_i(raw_lines[g]), .line_o(filt_lines[g]));
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  i2cs_cond_detect cond_i (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2cs_state_e       state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shift_q, tx_q;
  logic              rw_q;
  logic              addr_hit, cmd_ok;

  assign addr_hit = (shift_q[BYTE_W-1:2] == {ADDR_PREFIX, strap_code});
  assign cmd_ok   = !busy_reboot && !busy_nvm && (shift_q <= CMD_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      sda_oe    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
      rd_req    <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      rd_req    <= 1'b0;
      if (start_det) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        sda_oe    <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_CMD, ST_WDAT: begin
            if (scl_rise) begin
              shift_q   <= {shift_q[BYTE_W-2:0], sda_f};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
              bit_cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe  <= 1'b1;
                  rw_q    <= shift_q[0];
                  rd_req  <= shift_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_CMD) begin
                if (cmd_ok) begin
                  sda_oe    <= 1'b1;
                  cmd_valid <= 1'b1;
                  cmd_byte  <= shift_q;
                  state_q   <= ST_CMD_ACK;
                end else begin
                  state_q <= ST_HOLD;
                end
              end else begin
                sda_oe   <= 1'b1;
                wr_valid <= 1'b1;
                wr_data  <= shift_q;
                state_q  <= ST_WDAT_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                tx_q      <= {rd_data[BYTE_W-2:0], 1'b0};
                sda_oe    <= ~rd_data[BYTE_W-1];
                bit_cnt_q <= CNT_W'(1);
                state_q   <= ST_RDAT;
              end else begin
                sda_oe  <= 1'b0;
                state_q <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK, ST_WDAT_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              state_q <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (bit_cnt_q == LAST_BIT) begin
                sda_oe  <= 1'b0;
                state_q <= ST_RDAT_ACK;
              end else begin
                sda_oe    <= ~tx_q[BYTE_W-1];
                tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
          end
          ST_RDAT_ACK: begin
            if (scl_rise) begin
              if (!sda_f) rd_req  <= 1'b1;
              else        state_q <= ST_HOLD;
            end else if (scl_fall) begin
              tx_q      <= {rd_data[BYTE_W-2:0], 1'b0};
              sda_oe    <= ~rd_data[BYTE_W-1];
              bit_cnt_q <= CNT_W'(1);
              state_q   <= ST_RDAT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
  import i2cs_pkg::*;
#(
  parameter int CMD_LIMIT = 100
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              cmd_valid,
  input logic [BYTE_W-1:0] cmd_byte,
  input logic              wr_valid,
  input logic              rd_req,
  input logic              busy_reboot,
  input logic              busy_nvm,
  input logic              start_det,
  input logic              stop_det,
  input i2cs_state_e       state_q
);
  localparam logic [BYTE_W-1:0] CMD_MAX = BYTE_W'(CMD_LIMIT);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sda_oe && !cmd_valid && !wr_valid && !rd_req));

  a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !sda_oe);

  a_r4_start_to_addr: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state_q == ST_ADDR && !sda_oe));

  a_r5_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state_q == ST_IDLE && !sda_oe));

  a_r7_cmd_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  a_r8_busy_blocks_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(!busy_reboot && !busy_nvm));

  a_r8_cmd_in_range: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_byte <= CMD_MAX));

  a_r9_wr_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_valid, wr_valid, rd_req}));
endmodule

bind i2c_strap_slave i2cs_checker #(.CMD_LIMIT(CMD_LIMIT)) chk_i (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .cmd_valid(cmd_valid),
  .cmd_byte(cmd_byte), .wr_valid(wr_valid), .rd_req(rd_req),
  .busy_reboot(busy_reboot), .busy_nvm(busy_nvm),
  .start_det(start_det), .stop_det(stop_det), .state_q(state_q));

// File: tb/i2c_strap_slave_tb.sv
module i2c_strap_slave_tb_top;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_i = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus, sda_oe;
  logic [1:0] strap_code = 2'b00;
  logic busy_reboot = 1'b0, busy_nvm = 1'b0;
  logic cmd_valid, wr_valid, rd_req;
  logic [7:0] cmd_byte, wr_data, rd_data;

  int n_checks = 0, n_fail = 0;
  int n_cmd = 0, n_wr = 0, n_rd = 0;
  logic [7:0] last_cmd = 8'h00, last_wr = 8'h00;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  function automatic logic [7:0] rd_fn(int k);
    return 8'(k * 29 + 60);
  endfunction
  assign rd_data = rd_fn(n_rd);

  i2c_strap_slave #(.CMD_LIMIT(63)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_code(strap_code), .busy_reboot(busy_reboot), .busy_nvm(busy_nvm),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data));

  always @(posedge clk) if (!rst) begin
    if (cmd_valid) begin n_cmd <= n_cmd + 1; last_cmd <= cmd_byte; end
    if (wr_valid)  begin n_wr <= n_wr + 1;   last_wr <= wr_data;   end
    if (rd_req)    n_rd <= n_rd + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; scl_i = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_i = 1'b0; wq();
  endtask

  task automatic do_rstart();
    sda_m = 1'b1; wq();
    scl_i = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_i = 1'b0; wq();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq();
    scl_i = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_i = 1'b1; wq(2 * Q);
      scl_i = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_i = 1'b1; wq();
    ack = (sda_bus == 1'b0);
    wq();
    scl_i = 1'b0; wq();
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_i = 1'b1; wq();
      b[i] = sda_bus;
      wq();
      scl_i = 1'b0;
    end
    wq();
    sda_m = ~master_ack; wq();
    scl_i = 1'b1; wq(2 * Q);
    scl_i = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  typedef struct packed {
    logic [1:0] strap;
    logic [6:0] addr;
    logic [7:0] cmd;
    logic [7:0] data;
    logic       reboot;
    logic       nvm;
    logic       aack;
    logic       cack;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'b00, 7'h50, 8'h10, 8'h55, 1'b0, 1'b0, 1'b1, 1'b1},
    '{2'b01, 7'h53, 8'h3F, 8'hA3, 1'b0, 1'b0, 1'b1, 1'b1},
    '{2'b10, 7'h52, 8'h11, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'b11, 7'h56, 8'h40, 8'h33, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'b11, 7'h5E, 8'h01, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'b10, 7'h55, 8'h05, 8'h66, 1'b1, 1'b0, 1'b1, 1'b0},
    '{2'b00, 7'h50, 8'h06, 8'h77, 1'b0, 1'b1, 1'b1, 1'b0},
    '{2'b00, 7'h10, 8'h07, 8'h88, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    logic a;
    logic [7:0] rb;
    int c0, w0, r0;
    wq(10);
    // R1: reset state
    chk(!sda_oe && !cmd_valid && !wr_valid && !rd_req, "R1 reset quiet",
        {sda_oe, cmd_valid, wr_valid, rd_req}, 0);
    rst = 1'b0; wq(10);
    chk(!sda_oe, "R1 idle after reset", sda_oe, 0);

    // R2 R3 R7 R8 R9: vector table
    foreach (VEC[k]) begin
      strap_code = VEC[k].strap; busy_reboot = VEC[k].reboot; busy_nvm = VEC[k].nvm;
      c0 = n_cmd; w0 = n_wr;
      do_start();
      write_byte({VEC[k].addr, 1'b0}, a);
      chk(a == VEC[k].aack, "R2/R3 address ack", a, VEC[k].aack);
      write_byte(VEC[k].cmd, a);
      chk(a == (VEC[k].aack & VEC[k].cack), "R7/R8 command ack", a, VEC[k].aack & VEC[k].cack);
      write_byte(VEC[k].data, a);
      chk(a == (VEC[k].aack & VEC[k].cack), "R9/R8 data ack", a, VEC[k].aack & VEC[k].cack);
      do_stop();
      wq();
      chk(n_cmd - c0 == int'(VEC[k].aack & VEC[k].cack), "R7/R8 cmd strobes", n_cmd - c0, VEC[k].aack & VEC[k].cack);
      chk(n_wr - w0 == int'(VEC[k].aack & VEC[k].cack), "R9/R8 write strobes", n_wr - w0, VEC[k].aack & VEC[k].cack);
      if (VEC[k].aack & VEC[k].cack) begin
        chk(last_cmd == VEC[k].cmd, "R7 cmd byte", last_cmd, VEC[k].cmd);
        chk(last_wr == VEC[k].data, "R9 write byte", last_wr, VEC[k].data);
      end
    end
    busy_reboot = 1'b0; busy_nvm = 1'b0;

    // R10 R11: read two bytes, master NACKs the second
    strap_code = 2'b01; r0 = n_rd;
    do_start();
    write_byte(8'hA5, a);
    chk(a, "R10 read address ack", a, 1);
    read_byte(1'b1, rb);
    chk(rb == rd_fn(r0 + 1), "R10 first read byte", rb, rd_fn(r0 + 1));
    read_byte(1'b0, rb);
    chk(rb == rd_fn(r0 + 2), "R11 second read byte", rb, rd_fn(r0 + 2));
    read_byte(1'b0, rb);
    chk(rb == 8'hFF, "R11 line released after NACK", rb, 8'hFF);
    chk(n_rd - r0 == 2, "R11 no request after NACK", n_rd - r0, 2);
    do_stop();

    // R4: repeated START restarts address phase
    strap_code = 2'b10; c0 = n_cmd;
    do_start();
    write_byte(8'hA8, a);
    write_byte(8'h12, a);
    do_rstart();
    write_byte(8'hA8, a);
    chk(a, "R4 address after repeated start", a, 1);
    write_byte(8'h13, a);
    do_stop(); wq();
    chk(n_cmd - c0 == 2 && last_cmd == 8'h13, "R4 both commands", last_cmd, 8'h13);

    // R5: STOP ends the transfer
    do_start();
    write_byte(8'hA8, a);
    do_stop();
    scl_i = 1'b0; wq();
    write_byte(8'hA8, a);
    chk(!a, "R5 no ack after stop", a, 0);
    do_stop();

    // R6: STOP in same high interval as START is ignored
    sda_m = 1'b1; scl_i = 1'b1; wq();
    sda_m = 1'b0; wq();
    sda_m = 1'b1; wq();
    scl_i = 1'b0; wq();
    write_byte(8'hA8, a);
    chk(a, "R6 stop after start ignored", a, 1);
    do_stop();

    // R12: short SCL pulse inside address phase
    do_start();
    scl_i = 1'b1; wq(2); scl_i = 1'b0; wq();
    write_byte(8'hA8, a);
    chk(a, "R12 scl glitch ignored", a, 1);
    do_stop();

    // R12: short SDA pulse while idle is not a START
    sda_m = 1'b0; wq(2); sda_m = 1'b1; wq();
    scl_i = 1'b0; wq();
    write_byte(8'hA8, a);
    chk(!a, "R12 sda glitch ignored", a, 0);
    do_stop();

    wq(10);
    summary();
  end
endmodule